// File: doc/BRIEF.md
# Soft-Output Viterbi Decoder Core

This block decodes a rate-1/2, four-state recursive systematic convolutional code and produces soft results for an iterative (turbo) receiver. For each trellis step it accepts a signed soft systematic sample, a signed soft parity sample and a signed a-priori value supplied by the other constituent decoder. It runs an add-compare-select recursion over the four states and keeps, for every state, the survivor's bits and a per-bit reliability. A reliability is the smallest metric gap between the survivor and a competing path that disagrees on that bit.

Each decoded bit leaves the block a fixed number of steps after it entered. The bit comes out as a hard decision, a signed log-likelihood whose magnitude is the reliability, and an extrinsic value for the next half-iteration. The extrinsic value is the soft output with the step's own channel and a-priori inputs removed, multiplied by 0.75 and clipped to the input width. The surrounding system handles interleaving, iteration scheduling and channel scaling. Steps may arrive with idle cycles between them. Asserting the frame-start flag with a step restarts the trellis.

Top module: `sova_decoder`

## Requirements
- R1: The code has state bits d1 and d2, both zero at frame start. For input bit u the feedback is a = u xor d1 xor d2 and the parity is a xor d2, and the next state is d1 = a, d2 = old d1. With clean inputs (systematic and parity each at +A for a 1 and -A for a 0), every hard decision equals the transmitted bit, and a single inverted systematic sample inside a frame is corrected.
- R2: Branch metrics use bipolar bits (1 maps to +1, 0 to -1). The systematic bit is weighted by systematic sample plus a-priori value, and the parity bit by the parity sample. The path with the larger metric wins. With zero channel samples and nonzero a-priori values, each hard decision equals the sign of its a-priori value.
- R3: The result for step k of a frame appears with outValid in the cycle after step k+16 of the same frame is accepted. No result appears for the first 16 accepted steps of a frame.
- R4: outValid is high only in the cycle after an accepted step. outBit, outLlr and outExt hold their values while no step is accepted.
- R5: outLlr is two's complement, non-negative for a decided 1 and non-positive for a decided 0, with magnitude at most 127.
- R6: The reliability is the minimum metric gap at merges where the competitor differs from the survivor on that bit, saturated to 127. Every state starts at 127. With clean inputs of amplitude A and zero a-priori values, each magnitude is at least min(10·A, 127).
- R7: With e = outLlr − systematic sample − a-priori value of the same step, outExt = clip(e − floor(e/4)) to the range −32..31.
- R8: A step with frameStart high restarts the trellis in state 0, with the other states at a large negative metric, whatever the previous frame left behind.
- R9: Path metrics are renormalised by subtracting state 0's metric once it reaches the upper quarter of the 12-bit range, so a frame of 500 steps at full-scale amplitude decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A trellis step is presented this cycle |
| frameStart | input | 1 | This step is the first of a new frame |
| sysSoft | input | 6 | Signed soft systematic sample |
| parSoft | input | 6 | Signed soft parity sample |
| aPri | input | 6 | Signed a-priori value from the other decoder |
| outValid | output | 1 | Result for one bit is present |
| outBit | output | 1 | Hard decision |
| outLlr | output | 8 | Signed reliability (soft output) |
| outExt | output | 6 | Scaled, clipped extrinsic value |

## Verification
The checker checks on every cycle that outValid only follows an accepted step and never appears within the first 16 steps of a frame. It also checks that the outputs hold during idle cycles and that the sign of the soft output agrees with the hard decision. Only the bench's scenarios can show that the decisions are correct for a known encoded sequence. The same holds for the a-priori weighting, the reliability bound and its saturation, the extrinsic arithmetic, recovery from a corrupted sample, restart between frames and renormalisation over a long frame. These all need an encoder model and per-step expected values.

// File: rtl/sova_pkg.sv
package sova_pkg;
  localparam int NSTATE = 4;

  typedef struct packed {
    logic advance;
    logic restart;
    logic emit;
  } sovaStrobe_t;
endpackage

// File: rtl/sova_ctrl.sv
module sova_ctrl import sova_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        frameStart,
  output sovaStrobe_t strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] stepCnt;
  logic windowFull;

  assign windowFull = (stepCnt == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (inValid) begin
      if (frameStart) stepCnt <= CNT_W'(1);
      else if (!windowFull) stepCnt <= stepCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.advance = inValid;
    strobe.restart = inValid && frameStart;
    strobe.emit    = inValid && !frameStart && windowFull;
  end
endmodule

// File: rtl/sova_acs.sv
module sova_acs #(
  parameter int METRIC_W = 12,
  parameter int DEPTH    = 16,
  parameter int REL_W    = 7
) (
  input  logic signed [METRIC_W+2:0]    candA,
  input  logic signed [METRIC_W+2:0]    candB,
  input  logic                          bitA,
  input  logic                          bitB,
  input  logic [DEPTH-1:0]              pathA,
  input  logic [DEPTH-1:0]              pathB,
  input  logic [DEPTH-1:0][REL_W-1:0]   relA,
  input  logic [DEPTH-1:0][REL_W-1:0]   relB,
  output logic signed [METRIC_W-1:0]    newMetric,
  output logic [DEPTH-1:0]              newPath,
  output logic [DEPTH-1:0][REL_W-1:0]   newRel
);
  localparam int CAND_W = METRIC_W + 3;
  localparam logic [REL_W-1:0] REL_MAX = {REL_W{1'b1}};
  localparam logic signed [CAND_W-1:0] M_HI = CAND_W'((1 << (METRIC_W - 1)) - 1);
  localparam logic signed [CAND_W-1:0] M_LO = CAND_W'(-(1 << (METRIC_W - 1)));
  localparam logic signed [CAND_W-1:0] GAP_CAP = CAND_W'((1 << REL_W) - 1);

  logic pickB;
  logic signed [CAND_W-1:0] survCand, gap;
  logic [REL_W-1:0] delta;
  logic survBit;
  logic [DEPTH-1:0] survPath, compPath;
  logic [DEPTH-1:0][REL_W-1:0] survRel;

  always_comb begin
    pickB    = candB > candA;
    survCand = pickB ? candB : candA;
    gap      = pickB ? (candB - candA) : (candA - candB);
    delta    = (gap > GAP_CAP) ? REL_MAX : gap[REL_W-1:0];
    survBit  = pickB ? bitB : bitA;
    survPath = pickB ? pathB : pathA;
    compPath = pickB ? pathA : pathB;
    survRel  = pickB ? relB : relA;

    if (survCand > M_HI)      newMetric = M_HI[METRIC_W-1:0];
    else if (survCand < M_LO) newMetric = M_LO[METRIC_W-1:0];
    else                      newMetric = survCand[METRIC_W-1:0];

    newPath   = {survPath[DEPTH-2:0], survBit};
    newRel[0] = delta;
    for (int j = 0; j < DEPTH - 1; j++) begin
      if ((survPath[j] != compPath[j]) && (survRel[j] > delta)) newRel[j+1] = delta;
      else newRel[j+1] = survRel[j];
    end
  end
endmodule

// File: rtl/sova_datapath.sv
module sova_datapath import sova_pkg::*; #(
  parameter int SOFT_W   = 6,
  parameter int METRIC_W = 12,
  parameter int DEPTH    = 16,
  parameter int REL_W    = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sovaStrobe_t              strobe,
  input  logic signed [SOFT_W-1:0] sysSoft,
  input  logic signed [SOFT_W-1:0] parSoft,
  input  logic signed [SOFT_W-1:0] aPri,
  output logic                     outValid,
  output logic                     outBit,
  output logic signed [REL_W:0]    outLlr,
  output logic signed [SOFT_W-1:0] outExt
);
  localparam int CAND_W = METRIC_W + 3;
  localparam int BM_W   = SOFT_W + 3;
  localparam int LLR_W  = REL_W + 1;
  localparam int EXT_W  = LLR_W + 2;
  localparam int SEL_W  = $clog2(NSTATE);
  localparam logic [REL_W-1:0] REL_MAX = {REL_W{1'b1}};
  localparam logic signed [METRIC_W-1:0] INIT_NEG = METRIC_W'(-(1 << (METRIC_W - 3)));
  localparam logic signed [EXT_W-1:0] EXT_HI = EXT_W'((1 << (SOFT_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] EXT_LO = EXT_W'(-(1 << (SOFT_W - 1)));

  logic signed [METRIC_W-1:0] metricQ   [NSTATE];
  logic signed [METRIC_W-1:0] metricD   [NSTATE];
  logic signed [METRIC_W-1:0] srcMetric [NSTATE];
  logic [NSTATE-1:0][DEPTH-1:0] pathQ, pathD, srcPath;
  logic [NSTATE-1:0][DEPTH-1:0][REL_W-1:0] relQ, relD, srcRel;
  logic signed [SOFT_W-1:0] sysDly  [DEPTH];
  logic signed [SOFT_W-1:0] apriDly [DEPTH];

  logic signed [BM_W-1:0] sysTerm, parTerm;
  logic signed [BM_W-1:0] bm [4];
  logic signed [METRIC_W-1:0] base;
  logic renorm;

  // Branch metrics, start-of-frame substitution and renormalisation offset
  always_comb begin
    sysTerm = BM_W'(sysSoft) + BM_W'(aPri);
    parTerm = BM_W'(parSoft);
    for (int ux = 0; ux < 4; ux++) begin
      bm[ux] = (((ux & 2) != 0) ? sysTerm : -sysTerm) + (((ux & 1) != 0) ? parTerm : -parTerm);
    end
    renorm = !strobe.restart && !metricQ[0][METRIC_W-1] && metricQ[0][METRIC_W-2];
    base   = renorm ? metricQ[0] : '0;
    for (int s = 0; s < NSTATE; s++) begin
      if (strobe.restart) begin
        srcMetric[s] = (s == 0) ? '0 : INIT_NEG;
        srcPath[s]   = '0;
        for (int j = 0; j < DEPTH; j++) srcRel[s][j] = REL_MAX;
      end else begin
        srcMetric[s] = metricQ[s];
        srcPath[s]   = pathQ[s];
        srcRel[s]    = relQ[s];
      end
    end
  end

  // One add-compare-select unit per target state; state index = {d1, d2}
  for (genvar t = 0; t < NSTATE; t++) begin : g_state
    localparam int TA    = (t >> 1) & 1;
    localparam int TD1   = t & 1;
    localparam int PREDA = TD1 * 2;
    localparam int PREDB = TD1 * 2 + 1;
    localparam int UA    = TA ^ TD1;
    localparam int UB    = TA ^ TD1 ^ 1;
    localparam int UXA   = (UA << 1) | TA;
    localparam int UXB   = (UB << 1) | (TA ^ 1);

    logic signed [CAND_W-1:0] candA, candB;
    assign candA = CAND_W'(srcMetric[PREDA]) - CAND_W'(base) + CAND_W'(bm[UXA]);
    assign candB = CAND_W'(srcMetric[PREDB]) - CAND_W'(base) + CAND_W'(bm[UXB]);

    sova_acs #(.METRIC_W(METRIC_W), .DEPTH(DEPTH), .REL_W(REL_W)) u_acs (
      .candA    (candA),
      .candB    (candB),
      .bitA     (1'(UA)),
      .bitB     (1'(UB)),
      .pathA    (srcPath[PREDA]),
      .pathB    (srcPath[PREDB]),
      .relA     (srcRel[PREDA]),
      .relB     (srcRel[PREDB]),
      .newMetric(metricD[t]),
      .newPath  (pathD[t]),
      .newRel   (relD[t])
    );
  end

  // Oldest bit of the best survivor, and its extrinsic value
  logic [SEL_W-1:0] bestIdx;
  logic emitBit;
  logic [REL_W-1:0] emitMag;
  logic signed [LLR_W-1:0] emitLlr;
  logic signed [EXT_W-1:0] extRaw, extScaled;
  logic signed [SOFT_W-1:0] extSat;

  always_comb begin
    bestIdx = '0;
    for (int s = 1; s < NSTATE; s++) begin
      if (metricQ[s] > metricQ[bestIdx]) bestIdx = SEL_W'(s);
    end
    emitBit   = pathQ[bestIdx][DEPTH-1];
    emitMag   = relQ[bestIdx][DEPTH-1];
    emitLlr   = emitBit ? LLR_W'({1'b0, emitMag}) : -LLR_W'({1'b0, emitMag});
    extRaw    = EXT_W'(emitLlr) - EXT_W'(sysDly[DEPTH-1]) - EXT_W'(apriDly[DEPTH-1]);
    extScaled = extRaw - (extRaw >>> 2);
    if (extScaled > EXT_HI)      extSat = EXT_HI[SOFT_W-1:0];
    else if (extScaled < EXT_LO) extSat = EXT_LO[SOFT_W-1:0];
    else                         extSat = extScaled[SOFT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSTATE; s++) begin
        metricQ[s] <= (s == 0) ? '0 : INIT_NEG;
        pathQ[s]   <= '0;
        for (int j = 0; j < DEPTH; j++) relQ[s][j] <= REL_MAX;
      end
      for (int i = 0; i < DEPTH; i++) begin
        sysDly[i]  <= '0;
        apriDly[i] <= '0;
      end
      outValid <= 1'b0;
      outBit   <= 1'b0;
      outLlr   <= '0;
      outExt   <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outBit <= emitBit;
        outLlr <= emitLlr;
        outExt <= extSat;
      end
      if (strobe.advance) begin
        for (int s = 0; s < NSTATE; s++) metricQ[s] <= metricD[s];
        pathQ <= pathD;
        relQ  <= relD;
        for (int i = DEPTH - 1; i > 0; i--) begin
          sysDly[i]  <= sysDly[i-1];
          apriDly[i] <= apriDly[i-1];
        end
        sysDly[0]  <= sysSoft;
        apriDly[0] <= aPri;
      end
    end
  end
endmodule

// File: rtl/sova_decoder.sv
module sova_decoder import sova_pkg::*; #(
  parameter int SOFT_W   = 6,
  parameter int METRIC_W = 12,
  parameter int DEPTH    = 16,
  parameter int REL_W    = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     frameStart,
  input  logic signed [SOFT_W-1:0] sysSoft,
  input  logic signed [SOFT_W-1:0] parSoft,
  input  logic signed [SOFT_W-1:0] aPri,
  output logic                     outValid,
  output logic                     outBit,
  output logic signed [REL_W:0]    outLlr,
  output logic signed [SOFT_W-1:0] outExt
);
  sovaStrobe_t strobe;

  sova_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .frameStart(frameStart),
    .strobe    (strobe)
  );

  sova_datapath #(
    .SOFT_W(SOFT_W), .METRIC_W(METRIC_W), .DEPTH(DEPTH), .REL_W(REL_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sysSoft (sysSoft),
    .parSoft (parSoft),
    .aPri    (aPri),
    .outValid(outValid),
    .outBit  (outBit),
    .outLlr  (outLlr),
    .outExt  (outExt)
  );
endmodule

// File: rtl/sova_decoder_checker.sv
module sova_decoder_checker #(
  parameter int DEPTH  = 16,
  parameter int LLR_W  = 8,
  parameter int SOFT_W = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     frameStart,
  input logic                     outValid,
  input logic                     outBit,
  input logic signed [LLR_W-1:0]  outLlr,
  input logic signed [SOFT_W-1:0] outExt
);
  localparam int CNT_W = $clog2(DEPTH + 2);
  localparam logic signed [LLR_W-1:0] LLR_MIN = {1'b1, {(LLR_W-1){1'b0}}};

  logic [CNT_W-1:0] stepsSeen;

  always_ff @(posedge clk) begin
    if (!rstN) stepsSeen <= '0;
    else if (inValid) begin
      if (frameStart) stepsSeen <= CNT_W'(1);
      else if (stepsSeen != CNT_W'(DEPTH + 1)) stepsSeen <= stepsSeen + CNT_W'(1);
    end
  end

  // R3: a result needs more than DEPTH steps of the current frame
  a_r3_window_filled: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (stepsSeen == CNT_W'(DEPTH + 1)));

  // R3: the first step of a frame never produces a result
  a_r3_frame_start_blank: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && frameStart) |=> !outValid);

  // R4: a result only follows an accepted step
  a_r4_valid_after_step: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R4: outputs hold while no step is accepted
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outBit) && $stable(outLlr) && $stable(outExt)));

  // R5: sign of the soft output agrees with the decision
  a_r5_sign_matches_bit: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outBit ? (outLlr >= 0) : (outLlr <= 0)));

  // R5: magnitude never reaches the unrepresentable negative extreme
  a_r5_magnitude_bound: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLlr != LLR_MIN));
endmodule

bind sova_decoder sova_decoder_checker #(
  .DEPTH(DEPTH), .LLR_W(REL_W + 1), .SOFT_W(SOFT_W)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .frameStart(frameStart),
  .outValid  (outValid),
  .outBit    (outBit),
  .outLlr    (outLlr),
  .outExt    (outExt)
);

// File: tb/sova_decoder_bench.sv
module sova_decoder_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic frameStart = 1'b0;
  logic signed [5:0] sysSoft = '0;
  logic signed [5:0] parSoft = '0;
  logic signed [5:0] aPri = '0;
  logic outValid, outBit;
  logic signed [7:0] outLlr;
  logic signed [5:0] outExt;

  always #2 clk = ~clk;

  sova_decoder u_sova_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .sysSoft(sysSoft), .parSoft(parSoft), .aPri(aPri),
    .outValid(outValid), .outBit(outBit), .outLlr(outLlr), .outExt(outExt)
  );

  typedef struct {
    int    idx;
    bit    b;
    int    sys;
    int    apri;
    int    minMag;
    string tag;
  } item_t;

  item_t sb[$];
  int errors = 0;
  int checks = 0;
  int drvStep = 0;
  int accStep = -1;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit nextBit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  always @(posedge clk) if (inValid) accStep <= drvStep;

  // mode: 0 random, 1 zeros, 2 alternating, 3 ones, 4 a-priori only
  task automatic driveFrame(input int n, input int amp, input int mode, input string tag,
                            input int flipAt, input int gapEvery);
    bit d1 = 0;
    bit d2 = 0;
    for (int k = 0; k < n + DEPTH; k++) begin
      bit u, a, p;
      int s, q, ap, mm;
      item_t it;
      if (k >= n)         u = 0;
      else if (mode == 0) u = nextBit();
      else if (mode == 1) u = 0;
      else if (mode == 2) u = k[0];
      else if (mode == 3) u = 1;
      else                u = nextBit();
      a = u ^ d1 ^ d2;
      p = a ^ d2;
      d2 = d1;
      d1 = a;
      s  = u ? amp : -amp;
      q  = p ? amp : -amp;
      ap = 0;
      if (mode == 4) begin
        ap = s;
        s  = 0;
        q  = 0;
      end
      if (k == flipAt) s = -s;
      mm = (mode == 4 || flipAt >= 0) ? 0 : ((10 * amp > 127) ? 127 : 10 * amp);
      inValid    = 1'b1;
      frameStart = (k == 0);
      sysSoft    = 6'(s);
      parSoft    = 6'(q);
      aPri       = 6'(ap);
      drvStep    = k;
      if (k < n) begin
        it.idx = k; it.b = u; it.sys = s; it.apri = ap; it.minMag = mm; it.tag = tag;
        sb.push_back(it);
      end
      @(negedge clk);
      if (gapEvery > 0 && (k % gapEvery) == gapEvery - 1) begin
        inValid = 1'b0;
        frameStart = 1'b0;
        sysSoft = 6'(-s);
        @(negedge clk);
      end
    end
    inValid = 1'b0;
    frameStart = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        chk(0, "R4", "unexpected outValid", 1, 0);
      end else begin
        item_t it;
        int llr, mag, e, sc;
        it  = sb.pop_front();
        llr = int'(outLlr);
        mag = (llr < 0) ? -llr : llr;
        chk(accStep == it.idx + DEPTH, "R3", "result timing (accepted step)", accStep, it.idx + DEPTH);
        chk(outBit == it.b, it.tag, "hard decision", int'(outBit), int'(it.b));
        chk((outBit ? llr >= 0 : llr <= 0) && mag <= 127, "R5", "soft output sign/magnitude", llr, outBit ? mag : -mag);
        if (it.minMag > 0)
          chk(mag >= it.minMag, "R6", "reliability magnitude", mag, it.minMag);
        e  = llr - it.sys - it.apri;
        sc = e - (e >>> 2);
        if (sc > 31) sc = 31;
        if (sc < -32) sc = -32;
        chk(int'(outExt) == sc, "R7", "extrinsic value", int'(outExt), sc);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(outValid == 1'b0, "R4", "outValid during reset", int'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R4", "outValid after reset", int'(outValid), 0);

    driveFrame(60, 8, 0, "R1", -1, 0);   // R1 random clean frame
    driveFrame(20, 4, 1, "R6", -1, 0);   // R6 bound 40 on all-zero data
    driveFrame(24, 14, 3, "R6", -1, 0);  // R6 saturation at 127
    driveFrame(30, 6, 2, "R4", -1, 3);   // R4 idle cycles between steps
    driveFrame(40, 10, 4, "R2", -1, 0);  // R2 decisions from a-priori only
    driveFrame(40, 12, 0, "R1", 20, 0);  // R1 one inverted systematic sample
    driveFrame(500, 31, 0, "R9", -1, 0); // R9 long full-scale frame
    driveFrame(30, 9, 0, "R8", -1, 0);   // R8 restart after nonzero end state

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R3", "results still outstanding", sb.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule